// File: doc/BRIEF.md
# Translation-Buffer Pointer Register Bank

This block holds the registers that software uses to find a translation entry in an in-memory translation storage buffer (TSB) after a translation miss. It keeps one tag-access register, which holds the missing virtual page and its context. It also keeps two register sets, one for context zero and one for all other contexts. Each set has a buffer base register for each of the two page-size classes and one shared configuration register.

Reading one of the two pointer addresses returns the buffer address for that page-size class. The block picks the context-zero set or the nonzero set from the context field of the tag-access register. It then builds the pointer from the base, the buffer size, an optional split offset for class 1, and a slice of the tag-access value that is scaled by the page-size code in the configuration register. A tag-target view of the tag-access register can also be read.

Access is through a simple bus: an address, a write enable and write data. Read data is registered, so it appears one cycle after the address is presented. Fetching the entry from memory is left to the requester.

Top module: `tsbp_top`

## Requirements
- R1: After a synchronous reset, every register is zero. A read of any address then returns zero.
- R2: The writable registers sit at these addresses: 0 tag-access, 1 zero-context class-0 base, 2 zero-context class-1 base, 3 zero-context config, 4 nonzero-context class-0 base, 5 nonzero-context class-1 base, 6 nonzero-context config. A register written at an address reads back at the same address. `rd_data` shows the value for the address that was present at the previous rising clock edge.
- R3: A write to address 0 stores bits 59:0 as given and fills bits 63:60 with copies of bit 59.
- R4: If tag-access bits 12:0 are all zero, the pointers use the zero-context bases and config. Otherwise they use the nonzero-context set.
- R5: Pointer reads are at address 8 (class 0) and address 9 (class 1). Each pointer is the OR of two parts. The first part is the selected base with bits 12:0 cleared. The second part is tag-access shifted right by 9 + 3*code, keeping only bits 4 through 12+size, where size is base bits 3:0.
- R6: The page-size code is config bits 2:0 for class 0 and config bits 10:8 for class 1.
- R7: For class 1 only, when base bit 12 (split) is set, pointer bit 13+size is forced to one. Class 0 ignores the split bit.
- R8: A read of address 10 returns the tag target. Bits 41:0 hold tag-access bits 63:22, bits 60:48 hold tag-access bits 12:0, and all other bits are zero.
- R9: Writes to addresses 7 to 15 change no register. Reads of addresses 7 and 11 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address for both read and write |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Registered read data for the previous cycle's address |

## Verification
The pointer function is swept over every buffer size, every page-size code and both split settings. This sweep runs for each context kind and against three tag-access values. The class-1 code is offset from the class-0 code, so a swapped config field shows up as a mismatch. Decoy values in the unselected register set expose a wrong context choice. A split set on class 0 checks that the offset is gated by class. Separate patterns cover sign extension with bit 59 both set and clear, the tag-target field placement, and writes to read-only addresses that are followed by full read-back of every register.

// File: rtl/tsbp_pkg.sv
package tsbp_pkg;

    localparam int XLEN       = 64;
    localparam int ADDR_W     = 4;
    localparam int CTX_W      = 13;
    localparam int SZ_W       = 4;
    localparam int PS_W       = 3;
    localparam int NUM_CLS    = 2;
    localparam int BASE_LSB   = 13;
    localparam int SPLIT_BIT  = 12;
    localparam int IDX_LSB    = 4;
    localparam int SHIFT0     = 9;
    localparam int SHIFT_STEP = 3;
    localparam int PS_STRIDE  = 8;
    localparam int SEXT_BIT   = 59;
    localparam int TT_SRC_LSB = 22;
    localparam int TT_CTX_LSB = 48;

    typedef enum logic [ADDR_W-1:0] {
        A_TAG   = 4'd0,
        A_Z_B0  = 4'd1,
        A_Z_B1  = 4'd2,
        A_Z_CFG = 4'd3,
        A_N_B0  = 4'd4,
        A_N_B1  = 4'd5,
        A_N_CFG = 4'd6,
        A_PTR0  = 4'd8,
        A_PTR1  = 4'd9,
        A_TTGT  = 4'd10
    } reg_addr_e;

    typedef struct packed {
        logic [XLEN-1:0] base0;
        logic [XLEN-1:0] base1;
        logic [XLEN-1:0] cfg;
    } tsb_set_t;

    typedef struct packed {
        logic [XLEN-1:0] tag;
        tsb_set_t        zset;
        tsb_set_t        nset;
    } tsb_regs_t;

    function automatic logic [XLEN-1:0] sext_tag(input logic [XLEN-1:0] d);
        logic [XLEN-1:0] r;
        r = d;
        for (int b = SEXT_BIT + 1; b < XLEN; b++) r[b] = d[SEXT_BIT];
        return r;
    endfunction

    function automatic logic [XLEN-1:0] tag_target(input logic [XLEN-1:0] t);
        logic [XLEN-1:0] r;
        r = t >> TT_SRC_LSB;
        r[TT_CTX_LSB +: CTX_W] = t[CTX_W-1:0];
        return r;
    endfunction

    function automatic logic is_writable(input logic [ADDR_W-1:0] a);
        return a <= ADDR_W'(A_N_CFG);
    endfunction

endpackage

// File: rtl/tsbp_regs.sv
module tsbp_regs
    import tsbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [XLEN-1:0]   wr_data,
    output tsb_regs_t         regs_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_TAG:   regs_q.tag        <= sext_tag(wr_data);
                A_Z_B0:  regs_q.zset.base0 <= wr_data;
                A_Z_B1:  regs_q.zset.base1 <= wr_data;
                A_Z_CFG: regs_q.zset.cfg   <= wr_data;
                A_N_B0:  regs_q.nset.base0 <= wr_data;
                A_N_B1:  regs_q.nset.base1 <= wr_data;
                A_N_CFG: regs_q.nset.cfg   <= wr_data;
                default: ;
            endcase
        end
    end

    // R9: a write outside the writable window leaves every register alone
    assert_ro_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_writable(addr)) |=> $stable(regs_q));

    // R2: a config write lands unchanged
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_N_CFG) |=> (regs_q.nset.cfg == $past(wr_data)));

    // R3: upper tag-access bits always mirror bit 59
    assert_tag_sext_R3: assert property (@(posedge clk) disable iff (rst)
        (regs_q.tag[XLEN-1:SEXT_BIT+1] == {(XLEN-1-SEXT_BIT){regs_q.tag[SEXT_BIT]}}));

endmodule

// File: rtl/tsbp_ptr_calc.sv
module tsbp_ptr_calc #(
    parameter int XLEN       = 64,
    parameter int SZ_W       = 4,
    parameter int PS_W       = 3,
    parameter int BASE_LSB   = 13,
    parameter int IDX_LSB    = 4,
    parameter int SHIFT0     = 9,
    parameter int SHIFT_STEP = 3
) (
    input  logic [XLEN-1:0]          tag,
    input  logic [XLEN-1:BASE_LSB]   base_hi,
    input  logic                     split,
    input  logic [SZ_W-1:0]          tsb_size,
    input  logic [PS_W-1:0]          ps_code,
    output logic [XLEN-1:0]          ptr
);

    localparam int TOP_MAX = XLEN - 1;

    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] win;
    logic [XLEN-1:0] split_bit;
    int              top_bit;

    always_comb begin
        // highest index bit, saturated at the word width
        top_bit = (BASE_LSB - 1) + int'(tsb_size);
        if (top_bit > TOP_MAX) top_bit = TOP_MAX;

        shifted = tag >> (SHIFT0 + SHIFT_STEP * int'(ps_code));

        win = '0;
        for (int b = IDX_LSB; b < XLEN; b++) begin
            win[b] = (b <= top_bit) ? shifted[b] : 1'b0;
        end

        split_bit = '0;
        if (split && top_bit < TOP_MAX) split_bit[top_bit + 1] = 1'b1;

        ptr = {base_hi, {BASE_LSB{1'b0}}} | win | split_bit;
    end

endmodule

// File: rtl/tsbp_top.sv
module tsbp_top
    import tsbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        addr,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    output logic [63:0]       rd_data
);

    tsb_regs_t       regs_q;
    tsb_set_t        sel;
    logic            ctx_zero;
    logic [XLEN-1:0] ptr [NUM_CLS];
    logic [XLEN-1:0] rd_next;

    tsbp_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    assign ctx_zero = (regs_q.tag[CTX_W-1:0] == '0);
    assign sel      = ctx_zero ? regs_q.zset : regs_q.nset;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        logic [XLEN-1:0] base_c;
        logic [PS_W-1:0] ps_c;
        logic            split_c;

        assign base_c  = (c == 0) ? sel.base0 : sel.base1;
        assign ps_c    = sel.cfg[c*PS_STRIDE +: PS_W];
        assign split_c = (c == 1) ? base_c[SPLIT_BIT] : 1'b0;

        tsbp_ptr_calc #(
            .XLEN       (XLEN),
            .SZ_W       (SZ_W),
            .PS_W       (PS_W),
            .BASE_LSB   (BASE_LSB),
            .IDX_LSB    (IDX_LSB),
            .SHIFT0     (SHIFT0),
            .SHIFT_STEP (SHIFT_STEP)
        ) i_calc (
            .tag      (regs_q.tag),
            .base_hi  (base_c[XLEN-1:BASE_LSB]),
            .split    (split_c),
            .tsb_size (base_c[SZ_W-1:0]),
            .ps_code  (ps_c),
            .ptr      (ptr[c])
        );
    end

    always_comb begin
        case (addr)
            A_TAG:   rd_next = regs_q.tag;
            A_Z_B0:  rd_next = regs_q.zset.base0;
            A_Z_B1:  rd_next = regs_q.zset.base1;
            A_Z_CFG: rd_next = regs_q.zset.cfg;
            A_N_B0:  rd_next = regs_q.nset.base0;
            A_N_B1:  rd_next = regs_q.nset.base1;
            A_N_CFG: rd_next = regs_q.nset.cfg;
            A_PTR0:  rd_next = ptr[0];
            A_PTR1:  rd_next = ptr[1];
            A_TTGT:  rd_next = tag_target(regs_q.tag);
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_next;
    end

    // R5: pointers are always 16-byte aligned
    assert_ptr_align_R5: assert property (@(posedge clk) disable iff (rst)
        (ptr[0][IDX_LSB-1:0] == '0) && (ptr[1][IDX_LSB-1:0] == '0));

    // R7: class 0 never takes the split offset; bit 13+size follows the base
    assert_no_split_cls0_R7: assert property (@(posedge clk) disable iff (rst)
        ptr[0][BASE_LSB + int'(sel.base0[SZ_W-1:0])] ==
        sel.base0[BASE_LSB + int'(sel.base0[SZ_W-1:0])]);

    // R9: unmapped addresses read back as zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (addr == 4'd7 || addr > 4'd10) |=> (rd_data == '0));

    // R8: tag-target gap fields stay clear
    assert_ttgt_gaps_R8: assert property (@(posedge clk) disable iff (rst)
        (addr == A_TTGT) |=> (rd_data[47:42] == '0 && rd_data[63:61] == '0));

endmodule

// File: tb/test_tsbp_top.sv
module test_tsbp_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tsbp_top i_tsbp_top (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    function automatic logic [63:0] mix(input int k);
        logic [63:0] v;
        v = {32'(k) * 32'h9E3779B9, 32'(k + 11) * 32'h7FEB352D};
        return v ^ (v >> 17);
    endfunction

    function automatic logic [63:0] m_sext(input logic [63:0] d);
        return {{4{d[59]}}, d[59:0]};
    endfunction

    function automatic logic [63:0] m_ptr(input logic [63:0] ta, input logic [63:0] base,
                                          input logic [63:0] cfg, input int cls);
        logic [63:0] r;
        logic [63:0] sh;
        int sz;
        int p;
        sz = int'(base[3:0]);
        p  = (cls == 1) ? int'(cfg[10:8]) : int'(cfg[2:0]);
        r  = base & ~64'h1FFF;
        sh = ta >> (9 + 3 * p);
        for (int b = 4; b <= 12 + sz; b++) if (sh[b]) r[b] = 1'b1;
        if (cls == 1 && base[12]) r[13 + sz] = 1'b1;
        return r;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_all();
        logic [63:0] v;
        logic [63:0] ta;
        logic [63:0] b0;
        logic [63:0] b1;
        logic [63:0] cf;
        logic [63:0] shadow [7];

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state on every address class
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 reset read", v, 64'd0);
        end

        // R2: write and read back of the base/config registers
        for (int a = 1; a <= 6; a++) begin
            shadow[a] = mix(100 + a);
            wr(4'(a), shadow[a]);
        end
        for (int a = 1; a <= 6; a++) begin
            rd(4'(a), v);
            chk("R2 readback", v, shadow[a]);
        end

        // R3: sign extension in both directions
        wr(4'd0, 64'h0800_0000_0000_1234);
        rd(4'd0, v);
        chk("R3 sext set", v, 64'hF800_0000_0000_1234);
        wr(4'd0, 64'hF700_0000_0000_0001);
        rd(4'd0, v);
        chk("R3 sext clear", v, 64'h0700_0000_0000_0001);
        shadow[0] = 64'h0700_0000_0000_0001;

        // R8: tag target field placement
        ta = 64'h0ABC_DEF0_1234_5A5B;
        wr(4'd0, ta);
        rd(4'd10, v);
        chk("R8 tag target", v, ({3'b0, ta[12:0], 48'd0}) | (m_sext(ta) >> 22));
        shadow[0] = m_sext(ta);

        // R9: writes to read-only / unmapped addresses are ignored
        wr(4'd8, 64'hDEAD_BEEF_DEAD_BEEF);
        wr(4'd10, 64'h1111_2222_3333_4444);
        wr(4'd7, 64'h5555_6666_7777_8888);
        wr(4'd15, 64'h9999_AAAA_BBBB_CCCC);
        for (int a = 0; a <= 6; a++) begin
            rd(4'(a), v);
            chk("R9 ignored write", v, shadow[a]);
        end
        rd(4'd7, v);
        chk("R9 unmapped read 7", v, 64'd0);
        rd(4'd13, v);
        chk("R9 unmapped read 13", v, 64'd0);

        // R4 R5 R6 R7: sweep of size, page code and split for both context kinds
        for (int k = 0; k < 3; k++) begin
            for (int cz = 0; cz < 2; cz++) begin
                ta = mix(7 * k + cz + 1);
                if (cz == 1) ta[12:0] = '0;
                else         ta[0] = 1'b1;
                wr(4'd0, ta);
                ta = m_sext(ta);
                // decoys in the set that must not be chosen (R4)
                if (cz == 1) begin
                    wr(4'd4, ~64'd0); wr(4'd5, ~64'd0); wr(4'd6, 64'h0000_0000_0000_0507);
                end else begin
                    wr(4'd1, ~64'd0); wr(4'd2, ~64'd0); wr(4'd3, 64'h0000_0000_0000_0507);
                end
                for (int sz = 0; sz < 16; sz++) begin
                    for (int ps = 0; ps < 8; ps++) begin
                        for (int sp = 0; sp < 2; sp++) begin
                            b0 = mix(1000 + 97 * sz + 13 * ps + sp);
                            b0[3:0] = 4'(sz); b0[12] = sp[0];
                            b1 = mix(5000 + 31 * sz + 7 * ps + sp);
                            b1[3:0] = 4'(15 - sz); b1[12] = sp[0];
                            cf = mix(9000 + ps);
                            cf[2:0] = 3'(ps); cf[10:8] = 3'(ps + 3);
                            if (cz == 1) begin
                                wr(4'd1, b0); wr(4'd2, b1); wr(4'd3, cf);
                            end else begin
                                wr(4'd4, b0); wr(4'd5, b1); wr(4'd6, cf);
                            end
                            rd(4'd8, v);
                            chk("R4 R5 R6 R7 class0 pointer", v, m_ptr(ta, b0, cf, 0));
                            rd(4'd9, v);
                            chk("R4 R5 R6 R7 class1 pointer", v, m_ptr(ta, b1, cf, 1));
                        end
                    end
                end
            end
        end

        // R1: reset clears written state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(4'd0, v);
        chk("R1 reset after use", v, 64'd0);
        rd(4'd9, v);
        chk("R1 pointer after reset", v, 64'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule